// File: doc/BRIEF.md
# Modulo Overflow Alarm Timer

A 16-bit up-counting timer used as a one-shot or periodic alarm. Software programs a start value, a terminal (modulus) value, a prescaler and a clock selection through a small single-cycle register bus. The counter advances on prescaled ticks of a slow fixed-frequency reference, which arrives as a one-cycle strobe `ref_tick` in the bus clock domain. When the counter sits at the modulus and another tick arrives, it reloads the start value instead of incrementing, and an overflow is recorded.

Overflows can be accumulated: a threshold register asks for several overflows before the alarm flag rises. The flag drives the interrupt output when its enable bit is set. Clearing is a two-step handshake. Software first reads the status register while the flag is 1, then writes 0 to the flag bit. The handshake is built so that an overflow landing between the two steps cannot make the clear fail. An alarm N ticks away is set up with start value 0 and modulus N-1.

Top module: `ovf_alarm_timer`

## Requirements
- R1: After reset, status reads 0x00000000, count 0, modulus 0x0000FFFF, start value 0, threshold 0, and `irq` is 0.
- R2: Register offsets are status 0x00, count 0x04, modulus 0x08, start value 0x4C and threshold 0x84. Count, modulus and start value are 16 bits, and bits 31:16 read as zero.
- R3: A write of any data to the count register loads the counter with the start value on the next edge.
- R4: Status bits [4:3] select the clock. Only code 2 (reference strobe) advances the counter; any other code holds it.
- R5: Status bits [2:0] hold PS, and the counter advances once per 2^PS reference strobes. Any write to status restarts the division, so the first advance comes a full 2^PS strobes after that write.
- R6: On a tick with the counter equal to the modulus, the counter takes the start value and an overflow occurs; on other ticks it increments by one.
- R7: `irq` is 1 exactly while the flag (status bit 7) and the enable (status bit 6) are both 1.
- R8: A write of 1 to status bit 7 leaves the flag unchanged. A write of 0 that was not preceded by a status read showing the flag as 1 also leaves it unchanged.
- R9: A status read showing the flag as 1, followed by a status write with bit 7 at 0, clears the flag. This holds even if overflows happened between the read and the write.
- R10: If an overflow that would set the flag falls in the same cycle as a clearing write, the flag stays 1.
- R11: With threshold T nonzero, the flag rises only on every T-th overflow; with T = 0 it rises on every overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe from the fixed-frequency reference |
| bus_wr | input | 1 | Register write enable |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Alarm interrupt |

## Verification
The bench times the first advance after a status write with the largest divider, where a prescaler that was not restarted would step early or late. It lets overflows occur between the arming read and the clearing write; a design that compares the count at clear time would leave the flag stuck. It also lands a clearing write on an overflow edge, where a design that gave the clear priority would lose an alarm. Finally, it checks writes of 1 and unarmed writes of 0, which a naive write-to-clear flag would mishandle, and counts overflows against a threshold, where an off-by-one would raise the flag one period early or late.

// File: rtl/oat_pkg.sv
package oat_pkg;
  // register byte offsets
  localparam int OFS_STAT = 'h00;
  localparam int OFS_CNT  = 'h04;
  localparam int OFS_MOD  = 'h08;
  localparam int OFS_INIT = 'h4C;
  localparam int OFS_THR  = 'h84;

  // status bit positions
  localparam int ST_PS_LO   = 0;
  localparam int ST_CSEL_LO = 3;
  localparam int ST_IE      = 6;
  localparam int ST_FLAG    = 7;

  typedef enum logic [1:0] {
    CSEL_OFF  = 2'd0,
    CSEL_RSV1 = 2'd1,
    CSEL_REF  = 2'd2,
    CSEL_RSV3 = 2'd3
  } csel_e;
endpackage

// File: rtl/oat_prescaler.sv
module oat_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_tick,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  // last phase of the divider: 2^p - 1
  function automatic logic [DIV_W-1:0] last_phase(input logic [PS_W-1:0] p);
    logic [DIV_W:0] w;
    w = ({{DIV_W{1'b0}}, 1'b1} << p) - 1'b1;
    return w[DIV_W-1:0];
  endfunction

  logic [DIV_W-1:0] phase_q;
  logic             strobe;

  assign strobe = run && ref_tick;
  assign tick   = strobe && (phase_q == last_phase(ps));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (strobe)  phase_q <= tick ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/oat_counter.sv
module oat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] init,
  input  logic [CNT_W-1:0] modv,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt
);
  function automatic logic [CNT_W-1:0] next_val(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W-1:0] m,
                                                input logic [CNT_W-1:0] st);
    return (cur == m) ? st : cur + 1'b1;
  endfunction

  assign ovf_evt = tick && !load && (count == modv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= init;
    else if (tick) count <= next_val(count, modv, init);
  end
endmodule

// File: rtl/oat_flag.sv
module oat_flag #(
  parameter int THR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovf_evt,
  input  logic [THR_W-1:0] thr,
  input  logic             thr_wr,
  input  logic             stat_rd,
  input  logic             stat_wr,
  input  logic             wr_flag_bit,
  output logic             flag,
  output logic             flag_set_evt,
  output logic             flag_clr_evt
);
  logic [THR_W-1:0] seen_q;
  logic             armed_q;

  // true when this overflow completes the requested group
  function automatic logic group_done(input logic [THR_W-1:0] n,
                                      input logic [THR_W-1:0] t);
    logic [THR_W:0] nxt;
    nxt = {1'b0, n} + 1'b1;
    return (t == '0) || (nxt >= {1'b0, t});
  endfunction

  assign flag_set_evt = ovf_evt && group_done(seen_q, thr);
  assign flag_clr_evt = stat_wr && !wr_flag_bit && armed_q && !flag_set_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= '0;
      armed_q <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (thr_wr)       seen_q <= '0;
      else if (ovf_evt) seen_q <= flag_set_evt ? '0 : seen_q + 1'b1;

      if (stat_wr)              armed_q <= 1'b0;
      else if (stat_rd && flag) armed_q <= 1'b1;

      if (flag_set_evt)      flag <= 1'b1;
      else if (flag_clr_evt) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ovf_alarm_timer.sv
module ovf_alarm_timer
  import oat_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int THR_W  = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_MOD  = ADDR_W'(OFS_MOD);
  localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(OFS_INIT);
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(OFS_THR);

  logic [PS_W-1:0]  ps_q;
  csel_e            csel_q;
  logic             ie_q;
  logic [CNT_W-1:0] mod_q;
  logic [CNT_W-1:0] init_q;
  logic [THR_W-1:0] thr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  // named internal events
  logic stat_wr, stat_rd, cnt_wr, thr_wr;
  logic tick, ovf_evt, flag_set_evt, flag_clr_evt;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign stat_rd = bus_rd && (bus_addr == A_STAT);
  assign cnt_wr  = bus_wr && (bus_addr == A_CNT);
  assign thr_wr  = bus_wr && (bus_addr == A_THR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q   <= '0;
      csel_q <= CSEL_OFF;
      ie_q   <= 1'b0;
      mod_q  <= '1;
      init_q <= '0;
      thr_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_STAT: begin
          ps_q   <= bus_wdata[ST_PS_LO +: PS_W];
          csel_q <= csel_e'(bus_wdata[ST_CSEL_LO +: 2]);
          ie_q   <= bus_wdata[ST_IE];
        end
        A_MOD:   mod_q  <= bus_wdata[CNT_W-1:0];
        A_INIT:  init_q <= bus_wdata[CNT_W-1:0];
        A_THR:   thr_q  <= bus_wdata[THR_W-1:0];
        default: ;
      endcase
    end
  end

  oat_prescaler #(.PS_W(PS_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .run      (csel_q == CSEL_REF),
    .restart  (stat_wr),
    .ps       (ps_q),
    .tick     (tick)
  );

  oat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .load    (cnt_wr),
    .init    (init_q),
    .modv    (mod_q),
    .count   (cnt_q),
    .ovf_evt (ovf_evt)
  );

  oat_flag #(.THR_W(THR_W)) u_flag (
    .clk          (clk),
    .rst_n        (rst_n),
    .ovf_evt      (ovf_evt),
    .thr          (thr_q),
    .thr_wr       (thr_wr),
    .stat_rd      (stat_rd),
    .stat_wr      (stat_wr),
    .wr_flag_bit  (bus_wdata[ST_FLAG]),
    .flag         (flag_q),
    .flag_set_evt (flag_set_evt),
    .flag_clr_evt (flag_clr_evt)
  );

  assign irq = flag_q && ie_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT: begin
        bus_rdata[ST_PS_LO +: PS_W] = ps_q;
        bus_rdata[ST_CSEL_LO +: 2]  = csel_q;
        bus_rdata[ST_IE]            = ie_q;
        bus_rdata[ST_FLAG]          = flag_q;
      end
      A_CNT:   bus_rdata[CNT_W-1:0] = cnt_q;
      A_MOD:   bus_rdata[CNT_W-1:0] = mod_q;
      A_INIT:  bus_rdata[CNT_W-1:0] = init_q;
      A_THR:   bus_rdata[THR_W-1:0] = thr_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/oat_checker.sv
module oat_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             flag,
  input logic             tick,
  input logic             cnt_wr,
  input logic             ovf_evt,
  input logic             flag_set_evt,
  input logic             flag_clr_evt,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] init
);
  AST_LOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(init));  // R3

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cnt_wr |=> $stable(count));  // R4

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> count == $past(init));  // R6

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_wr && !ovf_evt |=> count == $past(count) + 1'b1);  // R6

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);  // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr_evt |=> flag);  // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_evt |=> flag);  // R10

  AST_SET_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_evt |-> ovf_evt);  // R11
endmodule

bind ovf_alarm_timer oat_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq          (irq),
  .flag         (flag_q),
  .tick         (tick),
  .cnt_wr       (cnt_wr),
  .ovf_evt      (ovf_evt),
  .flag_set_evt (flag_set_evt),
  .flag_clr_evt (flag_clr_evt),
  .count        (cnt_q),
  .init         (init_q)
);

// File: tb/tb_ovf_alarm_timer.sv
module tb_ovf_alarm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int total = 0;
  int bad = 0;

  localparam logic [7:0] S = 8'h00, C = 8'h04, M = 8'h08, I = 8'h4C, T = 8'h84;
  // status: csel=2 at [4:3], ie at [6]
  localparam logic [31:0] RUN_IE = 32'h50;

  always #2 clk = ~clk;

  ovf_alarm_timer dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // all bus tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 0);
    rd(S, d); check("R1 status", d, 32'h0);
    rd(C, d); check("R1 count", d, 32'h0);
    rd(M, d); check("R1 modulus", d, 32'h0000FFFF);
    rd(I, d); check("R1 start", d, 32'h0);
    rd(T, d); check("R1 threshold", d, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(M, 32'hABCD1234); rd(M, d); check("R2 modulus upper zero", d, 32'h1234);
    wr(I, 32'hFFFF5A5A); rd(I, d); check("R2 start upper zero", d, 32'h5A5A);
    wr(T, 32'h3);        rd(T, d); check("R2 threshold", d, 32'h3);
    wr(T, 32'h0);
  endtask

  task automatic t_load();
    logic [31:0] d;
    wr(I, 32'h10); wr(C, 32'hDEAD);
    rd(C, d); check("R3 count loads start", d, 32'h10);
  endtask

  task automatic t_stopped();
    logic [31:0] d;
    repeat (20) @(negedge clk);
    rd(C, d); check("R4 csel0 holds", d, 32'h10);
    wr(S, 32'h08);  // csel=1
    repeat (10) @(negedge clk);
    rd(C, d); check("R4 csel1 holds", d, 32'h10);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    wr(S, 32'h0); wr(I, 32'h0); wr(M, 32'hFFFF); wr(C, 32'h0);
    wr(S, 32'h17);  // csel=2, PS=7
    repeat (127) @(negedge clk);
    rd(C, d); check("R5 no step before 128", d, 32'h0);
    rd(C, d); check("R5 step at 128", d, 32'h1);
    wr(S, 32'h0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    wr(I, 32'h5); wr(M, 32'h7); wr(C, 32'h0);
    wr(S, RUN_IE);                 // edge E0
    repeat (2) @(negedge clk);     // after E2: count 7
    check("R6 no flag before wrap", {31'b0, irq}, 0);
    @(negedge clk);                // after E3: wrapped
    check("R6 flag on wrap", {31'b0, irq}, 1);
    rd(C, d); check("R6 reload start", d, 32'h5);
  endtask

  task automatic t_no_effect();
    logic [31:0] d;
    wr(S, 32'hC0);  // stop, ie=1, bit7=1
    check("R8 write one keeps flag", {31'b0, irq}, 1);
    wr(S, 32'h40);  // zero without arming read
    check("R8 unarmed zero keeps flag", {31'b0, irq}, 1);
    rd(S, d); check("R8 status after writes", d, 32'hC0);
    wr(S, 32'h40);
    check("R9 armed clear", {31'b0, irq}, 0);
    rd(S, d); check("R9 status cleared", d, 32'h40);
  endtask

  task automatic t_clear_race();
    logic [31:0] d;
    wr(I, 32'h0); wr(M, 32'h3); wr(C, 32'h0);
    wr(S, RUN_IE);                 // E0
    repeat (4) @(negedge clk);     // after E4: overflow
    check("R6 period four", {31'b0, irq}, 1);
    rd(S, d);                      // arm at E5
    check("R9 read shows flag", d[7], 1'b1);
    repeat (3) @(negedge clk);     // overflow at E8
    wr(S, RUN_IE);                 // clear at E9
    check("R9 clear after intervening overflow", {31'b0, irq}, 0);
    repeat (3) @(negedge clk);     // overflow at E12
    check("R9 flag sets again", {31'b0, irq}, 1);
    rd(S, d);                      // arm at E13
    repeat (2) @(negedge clk);
    wr(S, RUN_IE);                 // clear at E16 with overflow
    check("R10 overflow beats clear", {31'b0, irq}, 1);
    rd(S, d);                      // E17
    wr(S, RUN_IE);                 // E18
    check("R10 later clear works", {31'b0, irq}, 0);
    wr(S, 32'h0);
  endtask

  task automatic t_threshold();
    wr(T, 32'h3); wr(I, 32'h0); wr(M, 32'h1); wr(C, 32'h0);
    wr(S, RUN_IE);                 // E0; overflows at E2, E4, E6
    repeat (5) @(negedge clk);
    check("R11 no flag after two overflows", {31'b0, irq}, 0);
    @(negedge clk);
    check("R11 flag on third overflow", {31'b0, irq}, 1);
  endtask

  task automatic t_ie_gate();
    logic [31:0] d;
    wr(S, 32'h80);  // stop, ie=0, bit7=1
    check("R7 irq off with ie=0", {31'b0, irq}, 0);
    rd(S, d); check("R7 flag still set", d, 32'h80);
    wr(S, 32'h40);  // ie=1 (clears since armed)
    check("R7 irq after clear", {31'b0, irq}, 0);
    wr(T, 32'h0);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_load();
    t_stopped();
    t_prescale();
    t_overflow();
    t_no_effect();
    t_clear_race();
    t_threshold();
    t_ie_gate();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule